// File: doc/BRIEF.md
# Four-Channel Monitor Alarm Unit

This block collects digitized readings for four monitored quantities (a temperature, the supply voltage and two auxiliary analog inputs) from a shared converter that visits them in turn, once per frame. Each sample arrives on a valid/channel/data input. The block stores it and checks it against a high limit and a low limit that belong to that channel. It keeps sticky update flags and alarm flags, and it drives one interrupt line that is the masked OR of the alarm flags.

A host reaches the block through a word-wide register port with a combinational read path. Over this port the host loads the limits and the mask, reads the results and flags, and clears flags by writing zeros. While the host signals that a bus access is in progress, a temperature sample is not committed. The capture state machine parks it in a pending slot instead.

The capture state machine has two states. In ST_IDLE samples are committed as they arrive. ST_HOLD holds one deferred temperature sample. There are four transitions:
- DEFER (ST_IDLE to ST_HOLD): a temperature sample arrives while the bus is busy.
- RELEASE (ST_HOLD to ST_IDLE): the bus is free and no sample arrives, so the pending value is committed.
- SUPERSEDE (ST_HOLD to ST_IDLE): a newer temperature sample arrives on a free bus. It is committed and the pending value is dropped.
- STAY (ST_HOLD to ST_HOLD): in every other case.

Top module: `mon_alarm_unit`

## Requirements
- R1: After reset, every result and limit reads 0, the update register (address 12) reads 0, the alarm register (address 13) reads 0x0010, the mask (address 14) reads 0 and `irq` is 0.
- R2: A sample with `smp_valid` high for channel c is committed at that clock edge (channel codes: 0 temperature, 1 supply, 2 aux1, 3 aux2). From the next cycle its full 16 bits read at address c, and bit 7-c of the update register reads 1. Update bits are sticky: writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R3: Only bits 15:4 take part in a limit check. The high flag of a channel is set when the value is greater than the high limit. The low flag is set when the value is less than the low limit. A value equal to a limit sets neither flag.
- R4: Temperature values and limits are compared as two's complement. Supply, aux1 and aux2 are compared as unsigned.
- R5: The alarm register holds these flags: bit 7 temperature high, bit 6 temperature low, bit 5 supply high, bit 4 supply low, bit 3 aux1 high, bit 2 aux1 low, bit 1 aux2 high, bit 0 aux2 low.
- R6: Alarm flags are sticky. Writing 0 to a bit clears it and writing 1 leaves it unchanged. A later conversion that still violates a limit sets the flag again.
- R7: When a host write to the flag registers and a hardware set fall on the same clock edge, the hardware set wins.
- R8: The supply-low flag is 1 from reset until the first supply conversion. That conversion sets or clears the flag according to its own comparison. After that the flag behaves like any other sticky flag.
- R9: `irq` is the OR of (alarm AND mask), and address 15 bit 0 reads `irq`. A mask of 0 keeps `irq` at 0.
- R10: A temperature sample that arrives while `host_active` is high is not committed. It is committed on the first later cycle in which `host_active` is low and no sample arrives.
- R11: While a temperature sample is pending, samples for the other channels commit at once. A new temperature sample replaces the pending one if the bus is still busy. If the bus is free, the new sample is committed and the pending one is dropped.
- R12: High limits are at addresses 4 to 7 and low limits at addresses 8 to 11, in channel order. The mask is at address 14. All of them are written with `reg_wr` and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_ch | input | 2 | Channel code of the sample |
| smp_data | input | 16 | Left-justified sample value |
| host_active | input | 1 | Host bus access in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Masked alarm interrupt |

## Verification
The limit checks are driven with values just above, equal to and just below each limit. Some of these values differ from a limit only in the four ignored bits, which exposes any comparator that looks at the full word. Negative temperature values are placed against positive limits, and large aux values against mid-range limits, so that a signed/unsigned mix-up sets the opposite flag. Deferral patterns cover a held temperature sample with an aux sample arriving during the hold, a replacement while the bus is busy, and a newer sample arriving just as the bus frees. Together these show the ordering of commits. Flag writes of all ones, all zeros, and zeros on the same edge as a hardware set show the write-zero-to-clear rule and the priority of the hardware set.

// File: rtl/mon_alarm_pkg.sv
package mon_alarm_pkg;
    localparam int NCH      = 4;
    localparam int DATA_W   = 16;
    localparam int DROP_LSB = 4;
    localparam int ADDR_W   = 4;
    localparam int FLAG_W   = 2 * NCH;
    localparam int CH_W     = $clog2(NCH);

    localparam int A_RES = 0;
    localparam int A_HI  = A_RES + NCH;
    localparam int A_LO  = A_HI + NCH;
    localparam int A_UPD = A_LO + NCH;
    localparam int A_ALM = A_UPD + 1;
    localparam int A_MSK = A_ALM + 1;
    localparam int A_STS = A_MSK + 1;

    typedef enum logic [CH_W-1:0] {
        CH_TEMP   = 2'd0,
        CH_SUPPLY = 2'd1,
        CH_AUX1   = 2'd2,
        CH_AUX2   = 2'd3
    } chan_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } cap_state_e;

    typedef struct packed {
        logic              valid;
        chan_e             ch;
        logic [DATA_W-1:0] data;
    } commit_t;
endpackage

// File: rtl/mon_sample_fsm.sv
module mon_sample_fsm
    import mon_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CH_W-1:0]   smp_ch,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              host_active,
    output commit_t           cm
);
    cap_state_e        state_q, state_d;
    logic [DATA_W-1:0] pend_q;
    logic              load_pend;
    logic              is_temp;

    assign is_temp = smp_valid && (chan_e'(smp_ch) == CH_TEMP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pending temperature slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pend_q <= '0;
        else if (load_pend) pend_q <= smp_data;
    end

    // next state and commit outputs
    always_comb begin
        state_d   = state_q;
        load_pend = 1'b0;
        cm        = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (is_temp && host_active) begin
                    load_pend = 1'b1;            // DEFER
                    state_d   = ST_HOLD;
                end else if (smp_valid) begin
                    cm = '{valid: 1'b1, ch: chan_e'(smp_ch), data: smp_data};
                end
            end
            ST_HOLD: begin
                if (is_temp) begin
                    if (host_active) begin
                        load_pend = 1'b1;        // replace pending
                    end else begin
                        cm = '{valid: 1'b1, ch: CH_TEMP, data: smp_data};
                        state_d = ST_IDLE;       // SUPERSEDE
                    end
                end else if (smp_valid) begin
                    cm = '{valid: 1'b1, ch: chan_e'(smp_ch), data: smp_data};
                end else if (!host_active) begin
                    cm = '{valid: 1'b1, ch: CH_TEMP, data: pend_q};
                    state_d = ST_IDLE;           // RELEASE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mon_limit_cmp.sv
module mon_limit_cmp #(
    parameter bit SIGNED_CMP = 1'b0,
    parameter int DATA_W     = 16,
    parameter int DROP_LSB   = 4
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] hi_lim,
    input  logic [DATA_W-1:0] lo_lim,
    output logic              above,
    output logic              below
);
    localparam int KEEP = DATA_W - DROP_LSB;

    logic [KEEP-1:0] v_k, h_k, l_k;
    assign v_k = value[DATA_W-1:DROP_LSB];
    assign h_k = hi_lim[DATA_W-1:DROP_LSB];
    assign l_k = lo_lim[DATA_W-1:DROP_LSB];

    generate
        if (SIGNED_CMP) begin : g_signed
            assign above = $signed(v_k) > $signed(h_k);
            assign below = $signed(v_k) < $signed(l_k);
        end else begin : g_unsigned
            assign above = v_k > h_k;
            assign below = v_k < l_k;
        end
    endgenerate
endmodule

// File: rtl/mon_flag_bank.sv
module mon_flag_bank
    import mon_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  commit_t           cm,
    input  logic [NCH-1:0]    above,
    input  logic [NCH-1:0]    below,
    input  logic              wr_upd,
    input  logic              wr_alm,
    input  logic [FLAG_W-1:0] wdata,
    input  logic [FLAG_W-1:0] mask,
    output logic [FLAG_W-1:0] alm,
    output logic [NCH-1:0]    upd,
    output logic              irq
);
    localparam int SUP_LO_BIT = FLAG_W - 2 - 2 * int'(CH_SUPPLY);

    logic [FLAG_W-1:0] alm_set, alm_keep, alm_d;
    logic [NCH-1:0]    upd_set, upd_keep, upd_d;
    logic              sup_seen_q;
    logic              first_sup;

    always_comb begin
        alm_set = '0;
        upd_set = '0;
        for (int c = 0; c < NCH; c++) begin
            if (cm.valid && int'(cm.ch) == c) begin
                alm_set[FLAG_W-1-2*c] = above[c];
                alm_set[FLAG_W-2-2*c] = below[c];
                upd_set[NCH-1-c]      = 1'b1;
            end
        end
        first_sup = cm.valid && (cm.ch == CH_SUPPLY) && !sup_seen_q;
        alm_keep  = wr_alm ? wdata : '1;
        upd_keep  = wr_upd ? wdata[FLAG_W-1 -: NCH] : '1;
        alm_d     = (alm & alm_keep) | alm_set;
        upd_d     = (upd & upd_keep) | upd_set;
        if (first_sup) alm_d[SUP_LO_BIT] = below[int'(CH_SUPPLY)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm        <= FLAG_W'(1) << SUP_LO_BIT;
            upd        <= '0;
            sup_seen_q <= 1'b0;
        end else begin
            alm <= alm_d;
            upd <= upd_d;
            if (first_sup) sup_seen_q <= 1'b1;
        end
    end

    assign irq = |(alm & mask);
endmodule

// File: rtl/mon_alarm_unit.sv
module mon_alarm_unit
    import mon_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_valid,
    input  logic [1:0]  smp_ch,
    input  logic [15:0] smp_data,
    input  logic        host_active,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    commit_t           cm;
    logic [DATA_W-1:0] res_q [NCH];
    logic [DATA_W-1:0] hi_q  [NCH];
    logic [DATA_W-1:0] lo_q  [NCH];
    logic [FLAG_W-1:0] mask_q;
    logic [FLAG_W-1:0] alm_byte;
    logic [NCH-1:0]    upd_bits;
    logic [FLAG_W-1:0] upd_byte;
    logic [NCH-1:0]    above, below;

    mon_sample_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ch(smp_ch),
        .smp_data(smp_data), .host_active(host_active), .cm(cm)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q[c] <= '0;
                    hi_q[c]  <= '0;
                    lo_q[c]  <= '0;
                end else begin
                    if (cm.valid && int'(cm.ch) == c) res_q[c] <= cm.data;
                    if (reg_wr && reg_addr == ADDR_W'(A_HI + c)) hi_q[c] <= reg_wdata;
                    if (reg_wr && reg_addr == ADDR_W'(A_LO + c)) lo_q[c] <= reg_wdata;
                end
            end

            mon_limit_cmp #(
                .SIGNED_CMP(c == int'(CH_TEMP)), .DATA_W(DATA_W), .DROP_LSB(DROP_LSB)
            ) u_cmp (
                .value(cm.data), .hi_lim(hi_q[c]), .lo_lim(lo_q[c]),
                .above(above[c]), .below(below[c])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   mask_q <= '0;
        else if (reg_wr && reg_addr == ADDR_W'(A_MSK)) mask_q <= reg_wdata[FLAG_W-1:0];
    end

    mon_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n), .cm(cm), .above(above), .below(below),
        .wr_upd(reg_wr && reg_addr == ADDR_W'(A_UPD)),
        .wr_alm(reg_wr && reg_addr == ADDR_W'(A_ALM)),
        .wdata(reg_wdata[FLAG_W-1:0]), .mask(mask_q),
        .alm(alm_byte), .upd(upd_bits), .irq(irq)
    );

    assign upd_byte = {upd_bits, {(FLAG_W-NCH){1'b0}}};

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr[3:2])
            2'd0: reg_rdata = res_q[reg_addr[1:0]];
            2'd1: reg_rdata = hi_q[reg_addr[1:0]];
            2'd2: reg_rdata = lo_q[reg_addr[1:0]];
            default: begin
                unique case (int'(reg_addr))
                    A_UPD:   reg_rdata = DATA_W'(upd_byte);
                    A_ALM:   reg_rdata = DATA_W'(alm_byte);
                    A_MSK:   reg_rdata = DATA_W'(mask_q);
                    default: reg_rdata = DATA_W'(irq);
                endcase
            end
        endcase
    end
endmodule

// File: rtl/mon_alarm_chk.sv
module mon_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [3:0] reg_addr,
    input logic       host_active,
    input logic [7:0] mask,
    input logic [7:0] alm,
    input logic [7:0] upd,
    input logic       cm_valid,
    input logic [1:0] cm_ch,
    input logic       irq
);
    p_irq_off_when_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'h00) |-> !irq);

    p_temp_held_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_active |-> !(cm_valid && cm_ch == 2'd0));

    p_commit_marks_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |=> ((upd & (8'h80 >> $past(cm_ch))) != 8'h00));

    p_update_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 4'd12) |=> ((upd & $past(upd)) == $past(upd)));

    p_alarm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 4'd13) && !(cm_valid && cm_ch == 2'd1)
        |=> ((alm & $past(alm)) == $past(alm)));
endmodule

bind mon_alarm_unit mon_alarm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .host_active(host_active), .mask(mask_q), .alm(alm_byte), .upd(upd_byte),
    .cm_valid(cm.valid), .cm_ch(cm.ch), .irq(irq)
);

// File: tb/tb_mon_alarm_unit.sv
`timescale 1ns/1ps
module tb_mon_alarm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [1:0]  smp_ch = '0;
    logic [15:0] smp_data = '0;
    logic        host_active = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int tests = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mon_alarm_unit dut (.*);

    // behavioural reference model
    logic [15:0] m_res[4], m_hi[4], m_lo[4];
    logic [7:0]  m_alm, m_mask;
    logic [3:0]  m_upd;
    bit          m_hold, m_seen;
    logic [15:0] m_pend;
    bit          c_v;
    int          c_ch;
    logic [15:0] c_d;

    function automatic int fld(input logic [15:0] v, input int ch);
        int u = int'(v[15:4]);
        if (ch == 0 && u >= 2048) u -= 4096;
        return u;
    endfunction

    function automatic logic [15:0] m_read(input logic [3:0] a);
        if (a < 4)  return m_res[a];
        if (a < 8)  return m_hi[a-4];
        if (a < 12) return m_lo[a-8];
        if (a == 12) return {8'h00, m_upd, 4'h0};
        if (a == 13) return {8'h00, m_alm};
        if (a == 14) return {8'h00, m_mask};
        return {15'h0, |(m_alm & m_mask)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_res[i] = 0; m_hi[i] = 0; m_lo[i] = 0; end
            m_alm = 8'h10; m_mask = 0; m_upd = 0; m_hold = 0; m_seen = 0; m_pend = 0;
        end else begin
            c_v = 0; c_ch = 0; c_d = 0;
            if (smp_valid && smp_ch == 0 && host_active) begin
                m_hold = 1; m_pend = smp_data;
            end else if (smp_valid) begin
                c_v = 1; c_ch = int'(smp_ch); c_d = smp_data;
                if (smp_ch == 0) m_hold = 0;
            end else if (m_hold && !host_active) begin
                c_v = 1; c_ch = 0; c_d = m_pend; m_hold = 0;
            end
            begin
                bit ab, be;
                ab = c_v && fld(c_d, c_ch) > fld(m_hi[c_ch], c_ch);
                be = c_v && fld(c_d, c_ch) < fld(m_lo[c_ch], c_ch);
                if (reg_wr) begin
                    if (reg_addr >= 4 && reg_addr < 8)  m_hi[reg_addr-4] = reg_wdata;
                    if (reg_addr >= 8 && reg_addr < 12) m_lo[reg_addr-8] = reg_wdata;
                    if (reg_addr == 12) m_upd &= reg_wdata[7:4];
                    if (reg_addr == 13) m_alm &= reg_wdata[7:0];
                    if (reg_addr == 14) m_mask = reg_wdata[7:0];
                end
                if (c_v) begin
                    m_res[c_ch] = c_d;
                    m_upd[3-c_ch] = 1'b1;
                    if (ab) m_alm[7-2*c_ch] = 1'b1;
                    if (be) m_alm[6-2*c_ch] = 1'b1;
                    if (c_ch == 1 && !m_seen) begin m_alm[4] = be; m_seen = 1; end
                end
            end
        end
    end

    function automatic string tag_of(input logic [3:0] a);
        if (a < 4)   return "R2";
        if (a < 12)  return "R12";
        if (a == 12) return "R2";
        if (a == 13) return "R5";
        if (a == 14) return "R12";
        return "R9";
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (irq !== |(m_alm & m_mask)) begin
                fails++; $display("FAIL R9 irq actual=%0b expected=%0b", irq, |(m_alm & m_mask));
            end
            tests++;
            if (reg_rdata !== m_read(reg_addr)) begin
                fails++;
                $display("FAIL %s addr=%0d actual=%h expected=%h",
                         tag_of(reg_addr), reg_addr, reg_rdata, m_read(reg_addr));
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk); #1 reg_addr = a; #1 v = reg_rdata;
    endtask

    task automatic cyc(input bit sv, input int ch, input logic [15:0] sd,
                       input bit w, input logic [3:0] a, input logic [15:0] wd);
        @(negedge clk); #1;
        smp_valid = sv; smp_ch = 2'(ch); smp_data = sd;
        reg_wr = w; reg_addr = a; reg_wdata = wd;
        @(negedge clk); #1;
        smp_valid = 0; reg_wr = 0;
    endtask

    task automatic smp(input int ch, input logic [15:0] d); cyc(1, ch, d, 0, 0, 0); endtask
    task automatic wr(input logic [3:0] a, input logic [15:0] d); cyc(0, 0, 0, 1, a, d); endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1; tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(13, v); check("R1 alarm", v, 16'h0010);
        rd(12, v); check("R1 update", v, 16'h0000);
        rd(0, v);  check("R1 result", v, 16'h0000);
        rd(15, v); check("R1 irq", v, 16'h0000);
        // R8 flag powers up set and drives irq once unmasked (R9)
        wr(14, 16'h00FF); rd(15, v); check("R9 irq on", v, 16'h0001);
        wr(14, 16'h0000);
        // limits (R12)
        wr(4, 16'h1900); wr(8, 16'hF600);
        wr(5, 16'h8000); wr(9, 16'h2000);
        wr(6, 16'h7000); wr(10, 16'h1000);
        wr(7, 16'h9000); wr(11, 16'h0800);
        rd(4, v); check("R12 hi0", v, 16'h1900);
        rd(9, v); check("R12 lo1", v, 16'h2000);
        // R8 first supply conversion clears
        smp(1, 16'h5000);
        rd(13, v); check("R8 cleared", v, 16'h0000);
        rd(1, v);  check("R2 result", v, 16'h5000);
        rd(12, v); check("R2 update", v, 16'h0040);
        smp(1, 16'h1F00); rd(13, v); check("R8 low again", v, 16'h0010);
        wr(13, 16'h0000); rd(13, v); check("R6 clear", v, 16'h0000);
        // R3 ignored LSBs and equality
        smp(1, 16'h800F); rd(13, v); check("R3 equal", v, 16'h0000);
        smp(1, 16'h8010); rd(13, v); check("R3 above", v, 16'h0020);
        // R4 signed temperature, unsigned aux
        smp(0, 16'hF000); rd(13, v); check("R4 temp neg low", v, 16'h0060);
        smp(0, 16'h1A00); rd(13, v); check("R4 temp high", v, 16'h00E0);
        smp(2, 16'hF000); rd(13, v); check("R4 aux1 high", v, 16'h00E8);
        smp(3, 16'h0000); rd(13, v); check("R5 aux2 low", v, 16'h00E9);
        // R6 write one keeps, write zero clears, reset on repeat
        wr(13, 16'h00FF); rd(13, v); check("R6 keep", v, 16'h00E9);
        wr(13, 16'h0000); rd(13, v); check("R6 clear all", v, 16'h0000);
        smp(3, 16'h0000); rd(13, v); check("R6 re-set", v, 16'h0001);
        // R7 hardware set wins over same-cycle clear
        cyc(1, 3, 16'h0000, 1, 13, 16'h0000); rd(13, v); check("R7 alarm", v, 16'h0001);
        wr(12, 16'h0000);
        cyc(1, 2, 16'h3000, 1, 12, 16'h0000); rd(12, v); check("R7 update", v, 16'h0020);
        wr(12, 16'h0000); wr(13, 16'h0000);
        // R10 deferral
        @(negedge clk); #1 host_active = 1;
        smp(0, 16'h0500);
        rd(0, v);  check("R10 held", v, 16'h1A00);
        rd(12, v); check("R10 no update", v, 16'h0000);
        @(negedge clk); #1 host_active = 0;
        rd(0, v);  check("R10 released", v, 16'h0500);
        rd(12, v); check("R10 update", v, 16'h0080);
        // R11 aux during hold, replacement, supersede
        @(negedge clk); #1 host_active = 1;
        smp(0, 16'h0600);
        smp(2, 16'h3000);
        rd(2, v); check("R11 aux passes", v, 16'h3000);
        rd(0, v); check("R11 temp still held", v, 16'h0500);
        smp(0, 16'h0700);
        @(negedge clk); #1 host_active = 0;
        rd(0, v); check("R11 replaced", v, 16'h0700);
        @(negedge clk); #1 host_active = 1;
        smp(0, 16'h0800);
        @(negedge clk); #1 host_active = 0; smp_valid = 1; smp_ch = 0; smp_data = 16'h0900;
        @(negedge clk); #1 smp_valid = 0;
        rd(0, v); check("R11 supersede", v, 16'h0900);
        rd(0, v); check("R11 pending dropped", v, 16'h0900);
        // R9 masking
        wr(13, 16'h0000); smp(3, 16'h0000);
        wr(14, 16'h0002); rd(15, v); check("R9 masked off", v, 16'h0000);
        wr(14, 16'h0001); rd(15, v); check("R9 masked on", v, 16'h0001);
        rd(14, v); check("R12 mask", v, 16'h0001);
        wr(14, 16'h0000); rd(15, v); check("R9 zero mask", v, 16'h0000);
        repeat (4) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule